// File: doc/BRIEF.md
# Oversampled SPI Register-Access Target

This block is the target side of a register-access link carried over SPI. Everything inside it runs on one fast system clock. The serial clock, the select line and the host data line are treated as ordinary asynchronous inputs. Each one is brought into the system clock through a two-stage synchronizer. Edges of the serial clock are then found by comparing consecutive synchronized samples.

A frame starts when the select line goes low. The first bit is a direction flag (0 = host writes, 1 = host reads). The next bits are a register address, and the last bits are a data payload. All fields are sent most significant bit first, in SPI mode 0: the host-to-target line is sampled on rising serial-clock edges, and the target-to-host line changes on falling edges.

Once the last address bit has arrived, the block presents the address with a one-cycle strobe, so that the register logic behind it can answer a read within the same frame.

- **Write frames:** the payload is collected and presented with a one-cycle valid pulse.
- **Read frames:** the block captures a data word from its transmit input, qualified by a valid flag, and shifts it out.

Neither stream direction has a ready signal, because the serial link cannot be stalled:
- The receive valid pulse must be taken in the cycle it appears.
- Transmit data is accepted only inside its window. That window opens when the address is complete and closes at the first falling edge of the payload. Outside the window the transmit valid flag is ignored.

Top module: `spi_regacc_target`

## Requirements
- R1: While the active-low reset is asserted, and immediately after it is released, `addr`, `addr_vld`, `rd_wr`, `rx_data`, `rx_vld` and `miso_o` are all 0.
- R2: The first bit of a frame sets `rd_wr` (0 = write, 1 = read). It holds that value until the select line goes high, which clears it to 0.
- R3: The next ADDR_W bits, MSB first, form `addr`. After the last address bit is sampled, `addr_vld` is high for exactly one clock, and `addr` is stable in that clock and the next.
- R4: In a write frame, the DATA_W payload bits, MSB first, appear on `rx_data`. After the final payload bit is sampled, `rx_vld` is high for exactly one clock.
- R5: In a read frame, `tx_data` is captured if `tx_vld` is high at any clock after the address is complete and before the first payload falling edge. It is then driven on `miso_o` MSB first, each bit changing on a falling serial-clock edge, so the host reads it on the following rising edges.
- R6: `miso_o` is 0 during the header, throughout write frames, during a read frame whose data was never captured, and while the select line is high.
- R7: `tx_vld` raised after the first payload falling edge has no effect: `miso_o` stays 0 for the rest of that frame.
- R8: A frame deselected before all header and payload bits arrive produces no `rx_vld`. The next frame decodes from its first bit.
- R9: Serial-clock bits beyond the packet length are ignored. No second `rx_vld` is produced and `rx_data` keeps the payload.
- R10: A read frame never produces `rx_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must exceed four times the serial clock rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock from the host |
| sel_n_i | input | 1 | Frame select from the host, active low |
| mosi_i | input | 1 | Serial data from the host |
| miso_o | output | 1 | Serial data to the host |
| tx_data | input | DATA_W | Word returned to the host on a read |
| tx_vld | input | 1 | Qualifies `tx_data` inside the load window |
| addr | output | ADDR_W | Decoded register address |
| addr_vld | output | 1 | One-cycle strobe when `addr` is complete |
| rd_wr | output | 1 | Direction of the current frame, 1 = read |
| rx_data | output | DATA_W | Payload received in a write frame |
| rx_vld | output | 1 | One-cycle strobe when `rx_data` is new |

## Verification
The following are checked on every cycle:
- both strobes last exactly one clock;
- the two strobes never coincide;
- `addr` holds steady across its strobe;
- a receive strobe only occurs in a write frame;
- `miso_o` stays low whenever the frame is not a read.

The remaining behaviour is shown only by the bench's frames, by comparing against values computed from the frame contents. This covers the bit ordering of address, payload and returned word, the capture window for `tx_vld`, and the recovery after a truncated or over-long frame.

// File: rtl/spi_rat_pkg.sv
package spi_rat_pkg;

  typedef enum logic [1:0] {
    PH_DIR  = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2,
    PH_DONE = 2'd3
  } phase_t;

  // Field that the next sampled bit belongs to, given the bits already taken.
  function automatic phase_t phase_of(input int unsigned taken,
                                      input int unsigned addr_w,
                                      input int unsigned pkt_w);
    if (taken == 0)            return PH_DIR;
    else if (taken <= addr_w)  return PH_ADDR;
    else if (taken < pkt_w)    return PH_DATA;
    else                       return PH_DONE;
  endfunction

endpackage

// File: rtl/spi_rat_sync.sv
module spi_rat_sync #(
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/spi_rat_rx.sv
module spi_rat_rx
  import spi_rat_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  parameter int PKT_W  = 1 + ADDR_W + DATA_W,
  parameter int CNT_W  = $clog2(PKT_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              rise,
  input  logic              bit_in,
  output logic [CNT_W-1:0]  taken,
  output logic              rw,
  output logic [ADDR_W-1:0] addr_sh,
  output logic              addr_vld,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_vld
);
  localparam logic [CNT_W-1:0] LAST_ADDR = CNT_W'(ADDR_W);
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(PKT_W - 1);
  localparam logic [CNT_W-1:0] FULL      = CNT_W'(PKT_W);

  logic [DATA_W-1:0] data_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken    <= '0;
      rw       <= 1'b0;
      addr_sh  <= '0;
      data_sh  <= '0;
      rx_data  <= '0;
      addr_vld <= 1'b0;
      rx_vld   <= 1'b0;
    end else begin
      addr_vld <= 1'b0;
      rx_vld   <= 1'b0;
      if (!active) begin
        taken   <= '0;
        rw      <= 1'b0;
        addr_sh <= '0;
        data_sh <= '0;
      end else if (rise && taken < FULL) begin
        taken <= taken + 1'b1;
        unique case (phase_of(int'(taken), ADDR_W, PKT_W))
          PH_DIR:  rw <= bit_in;
          PH_ADDR: begin
            addr_sh <= {addr_sh[ADDR_W-2:0], bit_in};
            if (taken == LAST_ADDR) addr_vld <= 1'b1;
          end
          PH_DATA: begin
            data_sh <= {data_sh[DATA_W-2:0], bit_in};
            if (taken == LAST_BIT && !rw) begin
              rx_data <= {data_sh[DATA_W-2:0], bit_in};
              rx_vld  <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_rat_tx.sv
module spi_rat_tx #(
  parameter int HDR_W  = 8,
  parameter int DATA_W = 8,
  parameter int PKT_W  = HDR_W + DATA_W,
  parameter int CNT_W  = $clog2(PKT_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              fall,
  input  logic              rw,
  input  logic [CNT_W-1:0]  taken,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_vld,
  output logic              miso
);
  localparam logic [CNT_W-1:0] HDR_DONE = CNT_W'(HDR_W);
  localparam logic [CNT_W-1:0] FULL     = CNT_W'(PKT_W);

  logic [DATA_W-1:0] sh;
  logic              loaded, started;
  logic              in_payload;

  assign in_payload = (taken >= HDR_DONE) && (taken < FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '0;
      loaded  <= 1'b0;
      started <= 1'b0;
      miso    <= 1'b0;
    end else if (!active) begin
      sh      <= '0;
      loaded  <= 1'b0;
      started <= 1'b0;
      miso    <= 1'b0;
    end else begin
      if (rw && tx_vld && in_payload && !loaded && !started && !fall) begin
        sh     <= tx_data;
        loaded <= 1'b1;
      end
      if (fall && in_payload) begin
        started <= 1'b1;
        if (loaded) begin
          miso <= sh[DATA_W-1];
          sh   <= {sh[DATA_W-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/spi_regacc_target.sv
module spi_regacc_target #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              sel_n_i,
  input  logic              mosi_i,
  output logic              miso_o,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_vld,
  output logic [ADDR_W-1:0] addr,
  output logic              addr_vld,
  output logic              rd_wr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_vld
);
  localparam int HDR_W = 1 + ADDR_W;
  localparam int PKT_W = HDR_W + DATA_W;
  localparam int CNT_W = $clog2(PKT_W + 1);

  logic [2:0]       pins_s;
  logic             sclk_s, sel_n_s, mosi_s, sclk_prev;
  logic             rise, fall, active;
  logic [CNT_W-1:0] taken;

  spi_rat_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({sclk_i, sel_n_i, mosi_i}), .q(pins_s)
  );

  assign {sclk_s, sel_n_s, mosi_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev <= 1'b0;
    else        sclk_prev <= sclk_s;
  end

  assign rise   =  sclk_s && !sclk_prev;
  assign fall   = !sclk_s &&  sclk_prev;
  assign active = !sel_n_s;

  spi_rat_rx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PKT_W(PKT_W), .CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .active(active), .rise(rise), .bit_in(mosi_s),
    .taken(taken), .rw(rd_wr), .addr_sh(addr), .addr_vld(addr_vld),
    .rx_data(rx_data), .rx_vld(rx_vld)
  );

  spi_rat_tx #(.HDR_W(HDR_W), .DATA_W(DATA_W), .PKT_W(PKT_W), .CNT_W(CNT_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .active(active), .fall(fall), .rw(rd_wr),
    .taken(taken), .tx_data(tx_data), .tx_vld(tx_vld), .miso(miso_o)
  );
endmodule

// File: rtl/spi_rat_checker.sv
module spi_rat_checker #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              miso_o,
  input logic [ADDR_W-1:0] addr,
  input logic              addr_vld,
  input logic              rd_wr,
  input logic              rx_vld
);
  AST_ADDR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    addr_vld |=> !addr_vld);                                        // R3
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    addr_vld |=> $stable(addr));                                    // R3
  AST_RX_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_vld |=> !rx_vld);                                            // R4
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_vld && addr_vld));                                         // R4
  AST_NO_RX_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rx_vld |-> !rd_wr);                                             // R10
  AST_MISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_wr |-> !miso_o);                                            // R6
endmodule

bind spi_regacc_target spi_rat_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .miso_o(miso_o), .addr(addr),
  .addr_vld(addr_vld), .rd_wr(rd_wr), .rx_vld(rx_vld)
);

// File: tb/sim_spi_regacc_target.sv
`timescale 1ns/1ps
module sim_spi_regacc_target;
  localparam int AW = 7, DW = 8, HW = 1 + AW, PW = HW + DW;
  localparam int HALF = 5;  // system clocks per serial half period

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, sel_n = 1'b1, mosi = 1'b0;
  logic miso, addr_vld, rd_wr, rx_vld, tx_vld = 1'b0;
  logic [DW-1:0] tx_data = '0, rx_data;
  logic [AW-1:0] addr;

  int checks = 0, errors = 0;
  int n_addr = 0, n_rx = 0;
  logic [AW-1:0] seen_addr = '0;
  logic          seen_rw = 1'b0;
  logic [DW-1:0] seen_rx = '0;

  always #2.5 clk = ~clk;

  spi_regacc_target #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sel_n_i(sel_n), .mosi_i(mosi),
    .miso_o(miso), .tx_data(tx_data), .tx_vld(tx_vld), .addr(addr),
    .addr_vld(addr_vld), .rd_wr(rd_wr), .rx_data(rx_data), .rx_vld(rx_vld)
  );

  always @(negedge clk) begin
    if (addr_vld) begin n_addr++; seen_addr = addr; seen_rw = rd_wr; end
    if (rx_vld)   begin n_rx++;   seen_rx = rx_data; end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Send n bits MSB first; record miso just before each rising edge.
  task automatic frame(input logic [23:0] bits, input int n, input bit late,
                       output logic [23:0] mw);
    mw = '0;
    @(negedge clk) sel_n = 1'b0;
    repeat (6) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      if (late && i == HW + 1) tx_vld = 1'b1;
      mosi = bits[n-1-i];
      repeat (HALF) @(negedge clk);
      mw[n-1-i] = miso;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    sel_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  // {tx_vld, rw, addr, data}
  localparam logic [16:0] VEC [6] = '{
    {1'b0, 1'b0, 7'h15, 8'hA5},
    {1'b1, 1'b0, 7'h7F, 8'h00},
    {1'b1, 1'b1, 7'h00, 8'h3C},
    {1'b0, 1'b1, 7'h2A, 8'hFF},
    {1'b0, 1'b0, 7'h01, 8'h81},
    {1'b1, 1'b1, 7'h40, 8'h96}
  };

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [23:0] mw;
    int a0, r0;
    repeat (3) @(negedge clk);
    check({miso, addr_vld, rd_wr, rx_vld, addr, rx_data} == '0, "R1", "outputs in reset",
          {miso, addr_vld, rd_wr, rx_vld}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({miso, addr_vld, rd_wr, rx_vld, addr, rx_data} == '0, "R1", "outputs after reset",
          {miso, addr_vld, rd_wr, rx_vld}, 0);

    foreach (VEC[k]) begin
      logic en, rw; logic [AW-1:0] a; logic [DW-1:0] d; logic [DW-1:0] exp_m;
      {en, rw, a, d} = VEC[k];
      tx_vld = en; tx_data = d;
      a0 = n_addr; r0 = n_rx;
      frame({8'h0, rw, a, rw ? 8'hC3 : d}, PW, 1'b0, mw);
      check(n_addr - a0 == 1 && seen_addr == a, "R3", "address strobe/value", seen_addr, a);
      check(seen_rw == rw, "R2", "direction flag", seen_rw, rw);
      check(rd_wr == 1'b0, "R2", "flag cleared on deselect", rd_wr, 0);
      if (!rw) begin
        check(n_rx - r0 == 1 && seen_rx == d, "R4", "write payload", seen_rx, d);
        check(mw[PW-1:0] == '0, "R6", "miso quiet on write", mw, 0);
      end else begin
        exp_m = en ? d : '0;
        check(n_rx - r0 == 0, "R10", "no rx strobe on read", n_rx - r0, 0);
        check(mw[PW-1:0] == {8'h00, exp_m}, "R5", "read data on miso (R6 header)",
              mw[PW-1:0], {8'h00, exp_m});
      end
      tx_vld = 1'b0;
    end

    // R8: truncated write, then a clean frame
    a0 = n_addr; r0 = n_rx;
    frame({12'h0, 1'b0, 7'h11, 4'hF}, 12, 1'b0, mw);
    check(n_rx - r0 == 0, "R8", "no rx strobe on short frame", n_rx - r0, 0);
    r0 = n_rx;
    frame({8'h0, 1'b0, 7'h22, 8'hA3}, PW, 1'b0, mw);
    check(n_rx - r0 == 1 && seen_rx == 8'hA3 && seen_addr == 7'h22, "R8",
          "frame after truncation", {seen_addr, seen_rx}, {7'h22, 8'hA3});

    // R9: extra bits after the packet
    r0 = n_rx;
    frame({4'h0, 1'b0, 7'h33, 8'h5C, 4'hF}, PW + 4, 1'b0, mw);
    check(n_rx - r0 == 1, "R9", "single rx strobe on long frame", n_rx - r0, 1);
    check(rx_data == 8'h5C, "R9", "rx_data kept", rx_data, 8'h5C);

    // R7: tx_vld arrives after first payload falling edge
    tx_data = 8'hE7; tx_vld = 1'b0;
    frame({8'h0, 1'b1, 7'h05, 8'h00}, PW, 1'b1, mw);
    check(mw[PW-1:0] == '0, "R7", "late tx_vld ignored", mw[PW-1:0], 0);
    tx_vld = 1'b0;
    check(miso == 1'b0, "R6", "miso low when deselected", miso, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule